// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit virtual address into a 4 KiB physical page by searching a hashed translation table in memory. The table is made of groups of eight 8-byte entries. A request gives the address, whether it comes from the instruction side or the data side, and whether it is a write. The walker selects a segment register with the top address bits, hashes the page index with that register's segment identifier, and reads the first word of each entry in the selected group. It compares each word against a key built from the same values. If no entry in the first group matches, it searches a second group chosen by the complemented hash.

It fetches table words one at a time through a synchronous read port with one cycle of latency. It takes a new request only while idle. Each walk ends with a one-cycle done pulse that carries a hit flag and the physical page. On a data-side miss it also gives a fault-status word and the faulting address. Inserting entries into the table and checking permissions are handled elsewhere.

Top module: `hpt_walker`

## Requirements
- R1: The segment identifier is bits [23:0] of the segment register selected by vaddr[31:28]. The hash is (vaddr[27:12] XOR identifier) truncated to 23 bits. The table descriptor holds the table base in bits [31:16] (the base is that field shifted left by 16) and a 9-bit size mask in bits [8:0]. The group address is base + (hash[9:0] << 6) + ((hash[18:10] AND mask) << 16).
- R2: The compare key is 0x80000000 OR (identifier << 7) OR vaddr[27:22], with bit 6 (0x40) set only during the second pass. A word equal to the second-pass key never matches during the first pass.
- R3: In one pass, entry i's key word is read at group + 8*i for i = 0 to 7 in order, and the search stops at the first match. The matching entry's second word is then read at group + 8*i + 4. A hit in first-pass entry k costs k+2 reads.
- R4: After eight misses in the first group, the walker searches again with the 23-bit complement of the hash and the second-pass key. A hit in second-pass entry k costs k+10 reads, and a miss in both groups costs 16 reads.
- R5: On a hit, done pulses with hit=1 and phys_page equal to the second word with bits [11:0] cleared.
- R6: When the table descriptor is zero, the walk ends as a miss and reads no memory.
- R7: A data-side miss sets fault_status to 0x40000000 (no translation), ORed with 0x02000000 if the access was a write, and sets fault_addr to the virtual address.
- R8: An instruction-side miss and every hit give fault_status = 0 and fault_addr = 0.
- R9: Counting clock edges after the edge that accepts the request, done appears after 1 edge for a zero descriptor, 5+2k edges for a first-pass hit in entry k, 22+2k edges for a second-pass hit in entry k, and 34 edges for a miss in both groups.
- R10: done lasts exactly one cycle. Requests presented while a walk is in progress are ignored and do not change its result.
- R11: During and after synchronous reset, done, busy and mem_rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_is_data | input | 1 | 1 = data side, 0 = instruction side |
| req_is_write | input | 1 | 1 = write access |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register i at bits [32*i+31:32*i] |
| tbl_desc | input | 32 | Table descriptor: base [31:16], size mask [8:0] |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | 32 | Table byte address |
| mem_rd_data | input | 32 | Read word, valid the cycle after the strobe |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found |
| phys_page | output | 32 | 4 KiB-aligned physical page address |
| fault_status | output | 32 | Fault-status word for a data-side miss |
| fault_addr | output | 32 | Faulting virtual address for a data-side miss |

## Verification
The completion time of every walk follows directly from where the match occurs. The bench counts clock edges from the accepting edge to the first cycle in which done is seen and compares that count with 1, 5+2k, 22+2k or 34 edges. All outputs are sampled on falling edges, so each one is read in the same cycle that done shows and one cycle later to confirm that the pulse has ended. The bench also counts read strobes during each walk, which shows how far the scan went before it stopped.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int VSID_W      = 24;
    localparam int HASH_W      = 23;
    localparam int MASK_W      = 9;
    localparam int GRP_LO_W    = 10;
    localparam int GROUP_SHIFT = 6;
    localparam int TABLE_SHIFT = 16;
    localparam int ENTRY_SHIFT = 3;

    localparam logic [31:0] FS_NO_XLATE = 32'h4000_0000;
    localparam logic [31:0] FS_STORE    = 32'h0200_0000;
    localparam logic [31:0] KEY_VALID   = 32'h8000_0000;
    localparam logic [31:0] KEY_SECOND  = 32'h0000_0040;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HASH, ST_KEY_RD, ST_KEY_CMP, ST_LO_RD, ST_LO_CAP, ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [31:0] vaddr;
        logic        is_data;
        logic        is_write;
    } walk_req_t;

    typedef struct packed {
        logic        hit;
        logic [31:0] ppage;
        logic [31:0] fstat;
        logic [31:0] faddr;
    } walk_rsp_t;

    function automatic logic [HASH_W-1:0] first_hash(input logic [31:0] va,
                                                     input logic [VSID_W-1:0] vsid);
        logic [31:0] t;
        t = {16'b0, va[27:12]} ^ {8'b0, vsid};
        return t[HASH_W-1:0];
    endfunction

    function automatic logic [31:0] match_key(input logic [VSID_W-1:0] vsid,
                                              input logic [31:0] va,
                                              input logic second);
        return KEY_VALID | ({8'b0, vsid} << 7) | {26'b0, va[27:22]}
               | (second ? KEY_SECOND : 32'h0);
    endfunction

endpackage

// File: rtl/hpt_seg_sel.sv
module hpt_seg_sel
    import hpt_pkg::*;
#(
    parameter int NUM_SEG = 16,
    parameter int SEL_W   = $clog2(NUM_SEG)
) (
    input  logic [NUM_SEG*32-1:0] seg_flat,
    input  logic [SEL_W-1:0]      sel,
    output logic [VSID_W-1:0]     vsid
);
    logic [31:0] seg_arr [NUM_SEG];
    logic [VSID_W-1:0] vsid_arr [NUM_SEG];
    logic [NUM_SEG*(32-VSID_W)-1:0] unused_seg_hi;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign seg_arr[g]  = seg_flat[g*32 +: 32];
        assign vsid_arr[g] = seg_arr[g][VSID_W-1:0];
        assign unused_seg_hi[g*(32-VSID_W) +: (32-VSID_W)] = seg_arr[g][31:VSID_W];
    end

    assign vsid = vsid_arr[sel];
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
(
    input  logic [31:0]       vaddr,
    input  logic [VSID_W-1:0] vsid,
    input  logic              second,
    input  logic [31:0]       desc,
    output logic [31:0]       grp_addr,
    output logic [31:0]       key
);
    logic [HASH_W-1:0] h_first, h_sel;
    logic [MASK_W-1:0] hi_bits;
    logic [31:0]       grp_off, base;
    logic              unused_hash;

    always_comb begin
        h_first  = first_hash(vaddr, vsid);
        h_sel    = second ? ~h_first : h_first;
        hi_bits  = h_sel[GRP_LO_W+MASK_W-1:GRP_LO_W] & desc[MASK_W-1:0];
        grp_off  = (32'(h_sel[GRP_LO_W-1:0]) << GROUP_SHIFT)
                 | (32'(hi_bits) << TABLE_SHIFT);
        base     = {desc[31:TABLE_SHIFT], 16'b0};
        grp_addr = base + grp_off;
        key      = match_key(vsid, vaddr, second);
    end

    assign unused_hash = ^{h_sel[HASH_W-1:GRP_LO_W+MASK_W], desc[TABLE_SHIFT-1:MASK_W]};
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int NUM_SEG       = 16,
    parameter int GROUP_ENTRIES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [31:0]           req_vaddr,
    input  logic                  req_is_data,
    input  logic                  req_is_write,
    input  logic [NUM_SEG*32-1:0] seg_regs,
    input  logic [31:0]           tbl_desc,
    output logic                  mem_rd_en,
    output logic [31:0]           mem_addr,
    input  logic [31:0]           mem_rd_data,
    output logic                  busy,
    output logic                  done,
    output logic                  hit,
    output logic [31:0]           phys_page,
    output logic [31:0]           fault_status,
    output logic [31:0]           fault_addr
);
    localparam int SEL_W = $clog2(NUM_SEG);
    localparam int IDX_W = $clog2(GROUP_ENTRIES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_e       state_q;
    walk_req_t         req_q;
    walk_rsp_t         rsp_q, miss_rsp;
    logic              pass_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       grp_q, key_q;
    logic [VSID_W-1:0] vsid;
    logic [31:0]       hash_grp, hash_key;

    hpt_seg_sel #(.NUM_SEG(NUM_SEG)) u_seg_sel (
        .seg_flat (seg_regs),
        .sel      (req_q.vaddr[31 -: SEL_W]),
        .vsid     (vsid)
    );

    hpt_hash u_hash (
        .vaddr    (req_q.vaddr),
        .vsid     (vsid),
        .second   (pass_q),
        .desc     (tbl_desc),
        .grp_addr (hash_grp),
        .key      (hash_key)
    );

    always_comb begin
        miss_rsp       = '0;
        if (req_q.is_data) begin
            miss_rsp.fstat = FS_NO_XLATE | (req_q.is_write ? FS_STORE : 32'h0);
            miss_rsp.faddr = req_q.vaddr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            rsp_q   <= '0;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            grp_q   <= '0;
            key_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    req_q   <= '{vaddr: req_vaddr, is_data: req_is_data, is_write: req_is_write};
                    rsp_q   <= '0;
                    pass_q  <= 1'b0;
                    state_q <= ST_HASH;
                end
                ST_HASH: if (tbl_desc == '0) begin
                    rsp_q   <= miss_rsp;
                    state_q <= ST_DONE;
                end else begin
                    grp_q   <= hash_grp;
                    key_q   <= hash_key;
                    idx_q   <= '0;
                    state_q <= ST_KEY_RD;
                end
                ST_KEY_RD: state_q <= ST_KEY_CMP;
                ST_KEY_CMP: begin
                    if (mem_rd_data == key_q) begin
                        state_q <= ST_LO_RD;
                    end else if (idx_q == IDX_LAST) begin
                        if (!pass_q) begin
                            pass_q  <= 1'b1;
                            state_q <= ST_HASH;
                        end else begin
                            rsp_q   <= miss_rsp;
                            state_q <= ST_DONE;
                        end
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_KEY_RD;
                    end
                end
                ST_LO_RD: state_q <= ST_LO_CAP;
                ST_LO_CAP: begin
                    rsp_q   <= '{hit: 1'b1, ppage: {mem_rd_data[31:12], 12'b0},
                                 fstat: 32'h0, faddr: 32'h0};
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en    = (state_q == ST_KEY_RD) || (state_q == ST_LO_RD);
    assign mem_addr     = grp_q + (32'(idx_q) << ENTRY_SHIFT)
                        + ((state_q == ST_LO_RD) ? 32'd4 : 32'd0);
    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_DONE);
    assign hit          = rsp_q.hit;
    assign phys_page    = rsp_q.ppage;
    assign fault_status = rsp_q.fstat;
    assign fault_addr   = rsp_q.faddr;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_HIT_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> (fault_status == 32'h0 && fault_addr == 32'h0)); // R8
    AST_DATA_MISS_FAULT: assert property (@(posedge clk) disable iff (rst)
        (done && !hit && req_q.is_data) |-> (fault_status[30] && fault_addr == req_q.vaddr)); // R7
    AST_SECOND_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(pass_q) |-> ($past(idx_q) == IDX_LAST)); // R4
    AST_ZERO_DESC_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HASH && tbl_desc == '0) |=> (!mem_rd_en && done && !hit)); // R6
    AST_READ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en); // R11
endmodule

// File: tb/test_hpt_walker.sv
`timescale 1ns/1ps
module test_hpt_walker;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_is_data, req_is_write;
    logic [31:0]  req_vaddr;
    logic [511:0] seg_regs;
    logic [31:0]  tbl_desc;
    logic         mem_rd_en;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_rd_data;
    logic         busy, done, hit;
    logic [31:0]  phys_page, fault_status, fault_addr;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] pa [8];
    logic [31:0] pd [8];
    int np = 0;

    always #2 clk = ~clk;

    hpt_walker i_hpt_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_is_data(req_is_data), .req_is_write(req_is_write),
        .seg_regs(seg_regs), .tbl_desc(tbl_desc), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .busy(busy),
        .done(done), .hit(hit), .phys_page(phys_page),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] r;
        r = 32'h0;
        for (int i = 0; i < np; i++) if (pa[i] == a) r = pd[i];
        return r;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(mem_addr);

    function automatic logic [23:0] b_vsid(input logic [31:0] va);
        return seg_regs[int'(va[31:28])*32 +: 24];
    endfunction

    function automatic logic [31:0] b_grp(input logic [31:0] va, input bit sec);
        logic [22:0] h;
        logic [23:0] v;
        v = b_vsid(va);
        h = {7'b0, va[27:12]} ^ v[22:0];
        if (sec) h = ~h;
        return {tbl_desc[31:16], 16'h0} + ({22'b0, h[9:0]} << 6)
             + ({23'b0, h[18:10] & tbl_desc[8:0]} << 16);
    endfunction

    function automatic logic [31:0] b_key(input logic [31:0] va, input bit sec);
        return 32'h8000_0000 | ({8'h0, b_vsid(va)} << 7) | {26'h0, va[27:22]}
             | (sec ? 32'h40 : 32'h0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_walk(input logic [31:0] va, input logic d, input logic w,
                           input logic e_hit, input logic [31:0] e_pp,
                           input int e_lat, input int e_rd, input bit disturb);
        int n;
        int rd;
        logic [31:0] e_fs, e_fa;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_is_data = d; req_is_write = w;
        @(posedge clk);
        @(negedge clk);
        if (disturb) begin
            req_vaddr = va ^ 32'h1234_5000;
            req_is_data = ~d;
            req_is_write = ~w;
        end else req_valid = 1'b0;
        n = 0; rd = 0;
        while (!done && n < 200) begin
            if (mem_rd_en) rd++;
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 3) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        if (!e_hit && d) begin
            e_fs = 32'h4000_0000 | (w ? 32'h0200_0000 : 32'h0);
            e_fa = va;
        end else begin
            e_fs = 32'h0;
            e_fa = 32'h0;
        end
        chk("R9 latency", 32'(n), 32'(e_lat));
        chk("R5 hit", {31'b0, hit}, {31'b0, e_hit});
        chk("R1 R2 R5 phys_page", phys_page, e_pp);
        chk("R7 R8 fault_status", fault_status, e_fs);
        chk("R7 R8 fault_addr", fault_addr, e_fa);
        chk("R3 R4 R6 read count", 32'(rd), 32'(e_rd));
        @(posedge clk);
        @(negedge clk);
        chk("R10 done pulse", {31'b0, done}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] va, g, lo;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_is_data = 1'b0;
        req_is_write = 1'b0; tbl_desc = 32'h0040_0003;
        for (int i = 0; i < 16; i++)
            seg_regs[i*32 +: 32] = 32'hC000_0000
                                 | ((32'(i) * 32'h0002_F1B3 + 32'h0000_0711) & 32'h00FF_FFFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 done", {31'b0, done}, 32'h0);
        chk("R11 busy", {31'b0, busy}, 32'h0);
        chk("R11 mem_rd_en", {31'b0, mem_rd_en}, 32'h0);
        rst = 1'b0;

        // Sweep: pass, entry index, side; hit located by R1/R2 addressing (R3, R4, R5, R9)
        for (int sec = 0; sec < 2; sec++)
            for (int k = 0; k < 8; k++)
                for (int d = 0; d < 2; d++) begin
                    va = {4'(k*2 + sec), 28'h0ABC_D5A4 + 28'(k) * 28'h0135_7000
                                         + (d != 0 ? 28'h0024_6000 : 28'h0)};
                    np = 0;
                    g = b_grp(va, sec != 0);
                    lo = 32'h0F00_0321 + 32'(k) * 32'h0001_1000 + 32'(sec) * 32'h0100_0000;
                    pa[0] = g + 32'(k*8);     pd[0] = b_key(va, sec != 0);
                    pa[1] = g + 32'(k*8) + 4; pd[1] = lo;
                    np = 2;
                    if (sec != 0) begin
                        // R2: second-pass key placed in first group must not match
                        pa[2] = b_grp(va, 1'b0) + 32'(k*8); pd[2] = b_key(va, 1'b1);
                        np = 3;
                    end
                    if (sec == 0)
                        do_walk(va, d[0], k[0], 1'b1, lo & 32'hFFFF_F000, 5 + 2*k, k + 2, 1'b0);
                    else
                        do_walk(va, d[0], k[0], 1'b1, lo & 32'hFFFF_F000, 22 + 2*k, k + 10, 1'b0);
                end

        // R4 R7: data-side write miss in both groups
        np = 0;
        do_walk(32'h3456_7ABC, 1'b1, 1'b1, 1'b0, 32'h0, 34, 16, 1'b0);
        // R7: data-side read miss
        do_walk(32'h9876_5432, 1'b1, 1'b0, 1'b0, 32'h0, 34, 16, 1'b0);
        // R8: instruction-side miss
        do_walk(32'hE000_1000, 1'b0, 1'b1, 1'b0, 32'h0, 34, 16, 1'b0);

        // R6: zero descriptor, no reads
        tbl_desc = 32'h0;
        do_walk(32'h1111_2000, 1'b1, 1'b1, 1'b0, 32'h0, 1, 0, 1'b0);
        do_walk(32'h2222_3000, 1'b0, 1'b0, 1'b0, 32'h0, 1, 0, 1'b0);
        tbl_desc = 32'h0040_0003;

        // R10: requests during a walk are ignored
        va = 32'h5A5A_3000;
        np = 0;
        g = b_grp(va, 1'b0);
        pa[0] = g + 16;  pd[0] = b_key(va, 1'b0);
        pa[1] = g + 20;  pd[1] = 32'h7654_3FFF;
        np = 2;
        do_walk(va, 1'b1, 1'b0, 1'b1, 32'h7654_3000, 9, 4, 1'b1);
        @(negedge clk);
        chk("R10 idle after ignored request", {31'b0, busy}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule